// File: doc/BRIEF.md
# Dual-Mode Streaming FIFO

This block buffers a stream of data words between a producer and a consumer. Both sides use ready/valid handshakes. A word moves only in a cycle where valid and ready are both high on the same side. Words leave in the order they arrived. The first stored word is always presented at the output, without a separate read request.

A parameter chooses the clocking. In single-clock mode both sides run from `in_clk`, and `out_clk` and `out_rst_n` are left unused. In dual-clock mode each side runs from its own clock and reset, and the write and read pointers cross between the two domains as Gray code through two-flop synchronizers. Both modes are served by the same address-generator module, which is instantiated once per side.

Setting the address width to zero in single-clock mode removes the storage. The block then becomes a single registered pipeline stage that can carry one word per cycle.

Top module: `stream_fifo`

## Requirements
- R1: Every word accepted at the input appears at the output exactly once, in acceptance order, in both clocking modes.
- R2: With a non-zero address width, `in_ready` equals `!full` and `out_valid` equals `!empty`. A transfer happens only in a cycle where both valid and ready of that side are high.
- R3: The FIFO never holds more than 2^ADDR_W words and never presents a word that was not written. With the output idle, exactly 2^ADDR_W input transfers are accepted before `full` rises and `in_ready` falls.
- R4: After reset, `empty` is 1, `full` is 0, `out_valid` is 0 and `in_ready` is 1.
- R5: In single-clock mode the flags follow the occupancy within one cycle. A word accepted at a rising edge is offered at the output right after that edge. `full` falls right after the edge that completes a read from a full FIFO.
- R6: In dual-clock mode, after a write into an empty FIFO, `out_valid` rises after the second or third rising edge of `out_clk` that follows the write edge. Each pointer step changes one Gray bit.
- R7: In dual-clock mode the flags are conservative. After the first read from a full FIFO, `full` stays high until at least two rising edges of `in_clk` have passed. Once the FIFO is drained, `full` falls within a few `in_clk` cycles.
- R8: With ADDR_W = 0 and single-clock mode, the block is one register stage. `in_ready` equals `!out_valid || out_ready`. A word accepted at an edge is offered right after it. `full` equals `out_valid` and `empty` equals `!out_valid`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_clk | input | 1 | Write-side clock; it also clocks the read side in single-clock mode |
| in_rst_n | input | 1 | Active-low asynchronous reset, write side |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Block can take a word |
| in_data | input | DATA_W | Incoming word |
| out_clk | input | 1 | Read-side clock in dual-clock mode; unused otherwise |
| out_rst_n | input | 1 | Active-low asynchronous reset, read side in dual-clock mode |
| out_valid | output | 1 | A word is offered on `out_data` |
| out_ready | input | 1 | Consumer takes the offered word |
| out_data | output | DATA_W | Outgoing word |
| empty | output | 1 | No word available (read domain) |
| full | output | 1 | No space left (write domain) |

## Verification
In single-clock and pipeline mode every result is due right after the rising edge that causes it. The bench sets inputs at the falling edge, waits a short settle time so the combinational ready path is stable, and compares all outputs with a cycle-accurate occupancy model before the next rising edge. In dual-clock mode the delays depend on both clocks. The bench therefore counts `out_clk` edges after a write and accepts a window of two to three edges. For `full`, it checks the value at the first `in_clk` falling edge after a read, which is earlier than any synchronizer could react. The two clocks are given fractional phase offsets so that their edges never coincide.

// File: rtl/sfifo_pkg.sv
`timescale 1ns/100ps
package sfifo_pkg;
   // Which handshake side an address generator serves.
   typedef enum logic {SIDE_WR = 1'b0, SIDE_RD = 1'b1} sfifo_side_e;
endpackage

// File: rtl/sfifo_addr_gen.sv
`timescale 1ns/100ps
// One pointer with its status flag; the same module serves both clocking modes.
module sfifo_addr_gen
   import sfifo_pkg::*;
#(
   parameter int          ADDR_W   = 2,
   parameter bit          DUAL_CLK = 1'b0,
   parameter sfifo_side_e SIDE     = SIDE_WR,
   localparam int         PW       = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic [PW-1:0]     peer_ptr,  // Gray in dual-clock mode, binary otherwise
   output logic [PW-1:0]     ptr_out,   // same encoding rule as peer_ptr
   output logic [ADDR_W-1:0] addr,
   output logic              flag       // full on the write side, empty on the read side
);
   localparam logic [PW-1:0] WRAP_BIT = {1'b1, {ADDR_W{1'b0}}};

   function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
      return b;
   endfunction

   logic [PW-1:0] bin_q, bin_nxt, peer_view;

   assign bin_nxt = bin_q + PW'(inc);
   assign addr    = bin_q[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bin_q <= '0;
      else        bin_q <= bin_nxt;
   end

   if (DUAL_CLK) begin : g_cdc
      logic [PW-1:0] gray_q, sync1_q, sync2_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gray_q  <= '0;
            sync1_q <= '0;
            sync2_q <= '0;
         end else begin
            gray_q  <= to_gray(bin_nxt);
            sync1_q <= peer_ptr;
            sync2_q <= sync1_q;
         end
      end
      assign ptr_out   = gray_q;
      assign peer_view = from_gray(sync2_q);

      // R6: the crossing pointer moves by at most one Gray bit per edge
      a_r6_gray_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(gray_q ^ $past(gray_q)) <= 1);
   end else begin : g_direct
      assign ptr_out   = bin_q;
      assign peer_view = peer_ptr;
   end

   if (SIDE == SIDE_WR) begin : g_wr
      assign flag = (bin_q == (peer_view ^ WRAP_BIT));
      // R3: write pointer never runs more than one depth ahead of the read pointer it sees
      a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
         (bin_q - peer_view) <= WRAP_BIT);
   end else begin : g_rd
      assign flag = (bin_q == peer_view);
      // R3: read pointer never passes the write pointer it sees
      a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
         (peer_view - bin_q) <= WRAP_BIT);
   end

   // R5: a pointer advances by zero or one per edge
   a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (bin_q == $past(bin_q)) || (bin_q == $past(bin_q) + PW'(1)));
endmodule

// File: rtl/sfifo_mem.sv
`timescale 1ns/100ps
// Storage array: synchronous write, combinational read.
module sfifo_mem #(
   parameter int  DATA_W = 8,
   parameter int  ADDR_W = 2,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              wr_clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (wr_en) cells[wr_addr] <= wr_data;
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/sfifo_pipe.sv
`timescale 1ns/100ps
// Zero-depth variant: one registered handshake stage.
module sfifo_pipe #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   logic              vld_q;
   logic [DATA_W-1:0] dat_q;

   assign in_ready  = !vld_q || out_ready;
   assign out_valid = vld_q;
   assign out_data  = dat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         dat_q <= '0;
      end else if (in_ready) begin
         vld_q <= in_valid;
         if (in_valid) dat_q <= in_data;
      end
   end

   // R8: an accepted word is offered right after its edge
   a_r8_pipe_load: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
   // R9: a stalled word holds
   a_r9_pipe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/stream_fifo.sv
`timescale 1ns/100ps
module stream_fifo
   import sfifo_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 4,
   parameter bit DUAL_CLK = 1'b0
) (
   input  logic              in_clk,
   input  logic              in_rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              out_clk,
   input  logic              out_rst_n,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              empty,
   output logic              full
);
   localparam int PW = ADDR_W + 1;

   if (DATA_W < 1) begin : g_bad_width
      $error("stream_fifo: DATA_W must be at least 1");
   end
   if (ADDR_W < 0 || ADDR_W > 10) begin : g_bad_depth
      $error("stream_fifo: ADDR_W must lie in 0..10");
   end
   if (ADDR_W == 0 && DUAL_CLK) begin : g_bad_mode
      $error("stream_fifo: zero address width needs single-clock mode");
   end

   if (ADDR_W == 0) begin : g_pipe
      logic unused_pipe_side;
      assign unused_pipe_side = out_clk ^ out_rst_n;

      sfifo_pipe #(.DATA_W(DATA_W)) u_stage (
         .clk      (in_clk),
         .rst_n    (in_rst_n),
         .in_valid (in_valid),
         .in_ready (in_ready),
         .in_data  (in_data),
         .out_valid(out_valid),
         .out_ready(out_ready),
         .out_data (out_data)
      );
      assign full  = out_valid;
      assign empty = !out_valid;
   end else begin : g_fifo
      logic              rd_clk, rd_rst_n;
      logic              wr_inc, rd_inc, full_w, empty_r;
      logic [PW-1:0]     wr_ptr, rd_ptr;
      logic [ADDR_W-1:0] wr_addr, rd_addr;

      if (DUAL_CLK) begin : g_two_clk
         assign rd_clk   = out_clk;
         assign rd_rst_n = out_rst_n;
      end else begin : g_one_clk
         logic unused_sync_side;
         assign unused_sync_side = out_clk ^ out_rst_n;
         assign rd_clk   = in_clk;
         assign rd_rst_n = in_rst_n;
      end

      assign in_ready  = !full_w;
      assign out_valid = !empty_r;
      assign full      = full_w;
      assign empty     = empty_r;
      assign wr_inc    = in_valid && in_ready;
      assign rd_inc    = out_valid && out_ready;

      sfifo_addr_gen #(.ADDR_W(ADDR_W), .DUAL_CLK(DUAL_CLK), .SIDE(SIDE_WR)) u_wr_gen (
         .clk     (in_clk),
         .rst_n   (in_rst_n),
         .inc     (wr_inc),
         .peer_ptr(rd_ptr),
         .ptr_out (wr_ptr),
         .addr    (wr_addr),
         .flag    (full_w)
      );

      sfifo_addr_gen #(.ADDR_W(ADDR_W), .DUAL_CLK(DUAL_CLK), .SIDE(SIDE_RD)) u_rd_gen (
         .clk     (rd_clk),
         .rst_n   (rd_rst_n),
         .inc     (rd_inc),
         .peer_ptr(wr_ptr),
         .ptr_out (rd_ptr),
         .addr    (rd_addr),
         .flag    (empty_r)
      );

      sfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
         .wr_clk (in_clk),
         .wr_en  (wr_inc),
         .wr_addr(wr_addr),
         .wr_data(in_data),
         .rd_addr(rd_addr),
         .rd_data(out_data)
      );

      // R9: an offered word that is not taken stays offered and unchanged
      a_r9_out_hold: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
         (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
   end
endmodule

// File: tb/tb_stream_fifo.sv
`timescale 1ns/100ps
module tb_stream_fifo;
   logic clk = 1'b0, oclk = 1'b0, rst_n = 1'b0;
   int   checks = 0, errors = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;                          // 200 MHz
   initial begin #0.3; forever #3.5 oclk = ~oclk; end // unrelated read clock

   // single-clock FIFO, depth 4
   logic s_iv = 0, s_ir, s_ov, s_or = 0, s_em, s_fu;
   logic [7:0] s_id = 0, s_od;
   stream_fifo #(.DATA_W(8), .ADDR_W(2), .DUAL_CLK(1'b0)) dut (
      .in_clk(clk), .in_rst_n(rst_n), .in_valid(s_iv), .in_ready(s_ir), .in_data(s_id),
      .out_clk(clk), .out_rst_n(rst_n), .out_valid(s_ov), .out_ready(s_or), .out_data(s_od),
      .empty(s_em), .full(s_fu));

   // dual-clock FIFO, depth 4
   logic a_iv = 0, a_ir, a_ov, a_or = 0, a_em, a_fu;
   logic [7:0] a_id = 0, a_od;
   stream_fifo #(.DATA_W(8), .ADDR_W(2), .DUAL_CLK(1'b1)) dut_async (
      .in_clk(clk), .in_rst_n(rst_n), .in_valid(a_iv), .in_ready(a_ir), .in_data(a_id),
      .out_clk(oclk), .out_rst_n(rst_n), .out_valid(a_ov), .out_ready(a_or), .out_data(a_od),
      .empty(a_em), .full(a_fu));

   // pipeline stage
   logic p_iv = 0, p_ir, p_ov, p_or = 0, p_em, p_fu;
   logic [7:0] p_id = 0, p_od;
   stream_fifo #(.DATA_W(8), .ADDR_W(0), .DUAL_CLK(1'b0)) dut_pipe (
      .in_clk(clk), .in_rst_n(rst_n), .in_valid(p_iv), .in_ready(p_ir), .in_data(p_id),
      .out_clk(clk), .out_rst_n(rst_n), .out_valid(p_ov), .out_ready(p_or), .out_data(p_od),
      .empty(p_em), .full(p_fu));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // single-clock model
   logic [7:0] qm [4];
   int cnt = 0, hd = 0, tl = 0;
   bit stall_prev = 0;
   logic [7:0] data_prev = 0;

   task automatic sync_step(input bit v, input bit r, input logic [7:0] d);
      bit wr, rd;
      s_iv = v; s_or = r; s_id = d;
      #1;
      chk(s_em == (cnt == 0), "R2", s_em, cnt == 0);
      chk(s_fu == (cnt == 4), "R3", s_fu, cnt == 4);
      chk(s_ir == (cnt < 4), "R2", s_ir, cnt < 4);
      chk(s_ov == (cnt > 0), "R5", s_ov, cnt > 0);
      if (cnt > 0) chk(s_od == qm[hd], "R1", s_od, qm[hd]);
      if (stall_prev) chk(s_ov && s_od == data_prev, "R9", s_od, data_prev);
      stall_prev = s_ov && !r;
      data_prev  = s_od;
      wr = v && cnt < 4;
      rd = r && cnt > 0;
      @(posedge clk);
      if (rd) begin hd = (hd + 1) % 4; cnt--; end
      if (wr) begin qm[tl] = d; tl = (tl + 1) % 4; cnt++; end
      @(negedge clk);
   endtask

   // pipeline model
   bit pv = 0;
   logic [7:0] pd = 0;

   task automatic pipe_step(input bit v, input bit r, input logic [7:0] d);
      bit acc;
      p_iv = v; p_or = r; p_id = d;
      #1;
      chk(p_ov == pv, "R8", p_ov, pv);
      chk(p_fu == pv && p_em == !pv, "R8", {p_fu, p_em}, {pv, !pv});
      chk(p_ir == (!pv || r), "R8", p_ir, !pv || r);
      if (pv) chk(p_od == pd, "R8", p_od, pd);
      acc = v && (!pv || r);
      @(posedge clk);
      if (pv && r) pv = 0;
      if (acc) begin pv = 1; pd = d; end
      @(negedge clk);
   endtask

   initial begin
      int n, acc;
      bit got, rdy;
      logic [7:0] am [4];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4: reset state of all three
      chk(s_em && !s_fu && !s_ov && s_ir, "R4", {s_em, s_fu, s_ov, s_ir}, 4'b1001);
      chk(a_em && !a_fu && !a_ov && a_ir, "R4", {a_em, a_fu, a_ov, a_ir}, 4'b1001);
      chk(p_em && !p_fu && !p_ov && p_ir, "R4", {p_em, p_fu, p_ov, p_ir}, 4'b1001);

      // single clock: fill past depth (R3), drain, then mixed traffic
      for (int i = 0; i < 6; i++) sync_step(1, 0, 8'h10 + 8'(i));
      for (int i = 0; i < 4; i++) sync_step(0, 1, 8'h00);
      for (int i = 0; i < 80; i++) sync_step(i % 3 != 0, i % 5 != 1 && i % 7 != 2, 8'(i * 7 + 3));
      for (int i = 0; i < 40; i++) sync_step(1, i % 2 == 0, 8'(i + 8'h60));
      for (int i = 0; i < 6; i++) sync_step(0, 1, 8'h00);
      sync_step(0, 0, 8'h00);

      // pipeline stage sweep
      for (int i = 0; i < 60; i++) pipe_step(i % 4 != 3, i % 3 != 0, 8'(i * 5 + 1));
      for (int i = 0; i < 3; i++) pipe_step(0, 1, 8'h00);

      // dual clock: latency of first word (R6)
      a_iv = 1; a_id = 8'hA0; am[0] = 8'hA0;
      @(posedge clk); #0.1 a_iv = 0;
      n = 0; got = 0;
      for (int k = 0; k < 6; k++) if (!got) begin
         @(posedge oclk); n++;
         @(negedge oclk); got = a_ov;
      end
      chk(got && n >= 2 && n <= 3, "R6", n, 2);

      // dual clock: fill with output idle (R3, R7)
      acc = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         a_iv = 1; a_id = 8'hA1 + 8'(k);
         #0.1 rdy = a_ir;
         @(posedge clk);
         if (rdy) begin acc++; am[acc] = 8'hA1 + 8'(k); end
         #0.1;
      end
      a_iv = 0;
      @(negedge clk);
      chk(acc == 3, "R3", acc, 3);
      chk(a_fu == 1 && a_ir == 0, "R7", a_fu, 1);

      // dual clock: drain in order (R1), full stays until synchronized (R7)
      for (int k = 0; k < 4; k++) begin
         @(negedge oclk);
         chk(a_ov, "R2", a_ov, 1);
         chk(a_od == am[k], "R1", a_od, am[k]);
         a_or = 1;
         @(posedge oclk); #0.1 a_or = 0;
         if (k == 0) begin
            @(negedge clk);
            chk(a_fu == 1, "R7", a_fu, 1);
         end
      end
      @(negedge oclk);
      chk(a_em == 1 && a_ov == 0, "R2", a_em, 1);
      repeat (4) @(negedge clk);
      chk(a_fu == 0 && a_ir == 1, "R7", a_fu, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule